// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the serial test port of a chip. It runs the sixteen-state test-port state machine on the test clock. It holds a three-bit instruction register and decodes that register. From the decode it picks which data register is placed between the serial input and the serial output. The choices are a one-bit bypass stage, a 32-bit identification word, or an external boundary chain that lives outside this block.

For the boundary chain, the block supplies three strobes: capture, shift and update. It also supplies two pin-control modes. One mode makes the chip's pins follow the boundary update latches. The other mode disables every chip output. The serial output changes only on the falling test clock. It has a separate enable that is high only while a shift state is active.

Top module: `jtag_tap`

## Requirements
- R1: Driving `trst_n` low resets the block asynchronously. The controller goes to Test-Logic-Reset, the active instruction becomes 001 (IDCODE), `tdo_en` is 0 and `tdo` is 0.
- R2: Five rising clocks with `tms`=1 bring the controller to Test-Logic-Reset from any state. In Test-Logic-Reset the active instruction is forced to 001 on the falling clock.
- R3: In Capture-IR the instruction shifter loads 001. In Shift-IR it shifts one place per rising clock, taking `tdi` into the MSB and presenting the LSB on `tdo`.
- R4: The active instruction is loaded from the shifter on the falling clock in Update-IR. The decode is as follows. 000 is EXTEST. 001 is IDCODE. 010 is SAMPLE. 100 is CLAMP. 101 is HIGHZ. The codes 011, 110 and 111 act as BYPASS.
- R5: Under IDCODE, Capture-DR loads 32'h104B8067 into the data path. This word is version 0001, part 0x04B8, manufacturer 0x033 and a final 1. Shift-DR then presents it LSB first.
- R6: BYPASS, CLAMP and HIGHZ place the one-bit bypass stage in the path. This stage loads 0 in Capture-DR and delays `tdi` by one clock in Shift-DR.
- R7: EXTEST and SAMPLE raise `bsr_sel` and route `bsr_so` to `tdo`. `bsr_capture`, `bsr_shift` and `bsr_update` are high in Capture-DR, Shift-DR and Update-DR respectively, and only while `bsr_sel` is high.
- R8: `tdo` and `tdo_en` change only on the falling clock. `tdo_en` is 1 only in Shift-IR or Shift-DR. In every other state `tdo` is 0.
- R9: `pin_ctl` is 1 exactly when the active instruction is EXTEST or CLAMP. `pin_hiz` is 1 exactly when the active instruction is HIGHZ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tms | input | 1 | Mode select, sampled on the rising clock |
| tdi | input | 1 | Serial data in |
| trst_n | input | 1 | Asynchronous reset, active low |
| bsr_so | input | 1 | Serial output of the external boundary chain |
| tdo | output | 1 | Serial data out, updated on the falling clock |
| tdo_en | output | 1 | Output enable for `tdo` |
| bsr_sel | output | 1 | Boundary chain is the selected data register |
| bsr_capture | output | 1 | Boundary capture strobe |
| bsr_shift | output | 1 | Boundary shift strobe |
| bsr_update | output | 1 | Boundary update strobe |
| pin_ctl | output | 1 | Pins follow the boundary update latches |
| pin_hiz | output | 1 | All chip outputs disabled |

## Verification
The bench builds the block with its default parameters: a three-bit instruction and a 32-bit identification word. With three instruction bits, all eight opcodes can be loaded and checked, including the three aliases of bypass. With the full identification width, every bit of the captured word is read back. A behavioural model of the state machine and its registers runs alongside the block and is compared after every falling clock. Dedicated checks cover the following cases:
- the captured instruction pattern,
- the five-clock reset path,
- an asynchronous reset during a shift,
- the one-clock delay of the bypass stage.

// File: rtl/jtag_tap.sv
module jtag_tap #(
  parameter int          IR_W     = 3,
  parameter int          ID_W     = 32,
  parameter logic [31:0] ID_VALUE = 32'h104B8067
) (
  input  logic tck,
  input  logic tms,
  input  logic tdi,
  input  logic trst_n,
  input  logic bsr_so,
  output logic tdo,
  output logic tdo_en,
  output logic bsr_sel,
  output logic bsr_capture,
  output logic bsr_shift,
  output logic bsr_update,
  output logic pin_ctl,
  output logic pin_hiz
);

  localparam logic [IR_W-1:0] OP_EXTEST = IR_W'(0);
  localparam logic [IR_W-1:0] OP_IDCODE = IR_W'(1);
  localparam logic [IR_W-1:0] OP_SAMPLE = IR_W'(2);
  localparam logic [IR_W-1:0] OP_CLAMP  = IR_W'(4);
  localparam logic [IR_W-1:0] OP_HIGHZ  = IR_W'(5);
  localparam logic [IR_W-1:0] IR_CAPT   = IR_W'(1);
  localparam logic [ID_W-1:0] ID_WORD   = ID_W'(ID_VALUE);

  typedef enum logic [3:0] {
    ST_TLR   = 4'hF, ST_RTI   = 4'hC, ST_SELDR = 4'h7, ST_CDR  = 4'h6,
    ST_SDR   = 4'h2, ST_E1DR  = 4'h1, ST_PDR   = 4'h3, ST_E2DR = 4'h0,
    ST_UDR   = 4'h5, ST_SELIR = 4'h4, ST_CIR   = 4'hE, ST_SIR  = 4'hA,
    ST_E1IR  = 4'h9, ST_PIR   = 4'hB, ST_E2IR  = 4'h8, ST_UIR  = 4'hD
  } tap_st_t;

  tap_st_t          state, state_nx;
  logic [IR_W-1:0]  ir, ir_sr;
  logic [ID_W-1:0]  id_sr;
  logic             byp;
  logic             sel_id, dr_bit;

  always_comb begin
    case (state)
      ST_TLR:   state_nx = tms ? ST_TLR   : ST_RTI;
      ST_RTI:   state_nx = tms ? ST_SELDR : ST_RTI;
      ST_SELDR: state_nx = tms ? ST_SELIR : ST_CDR;
      ST_CDR:   state_nx = tms ? ST_E1DR  : ST_SDR;
      ST_SDR:   state_nx = tms ? ST_E1DR  : ST_SDR;
      ST_E1DR:  state_nx = tms ? ST_UDR   : ST_PDR;
      ST_PDR:   state_nx = tms ? ST_E2DR  : ST_PDR;
      ST_E2DR:  state_nx = tms ? ST_UDR   : ST_SDR;
      ST_UDR:   state_nx = tms ? ST_SELDR : ST_RTI;
      ST_SELIR: state_nx = tms ? ST_TLR   : ST_CIR;
      ST_CIR:   state_nx = tms ? ST_E1IR  : ST_SIR;
      ST_SIR:   state_nx = tms ? ST_E1IR  : ST_SIR;
      ST_E1IR:  state_nx = tms ? ST_UIR   : ST_PIR;
      ST_PIR:   state_nx = tms ? ST_E2IR  : ST_PIR;
      ST_E2IR:  state_nx = tms ? ST_UIR   : ST_SIR;
      ST_UIR:   state_nx = tms ? ST_SELDR : ST_RTI;
      default:  state_nx = ST_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n) state <= ST_TLR;
    else         state <= state_nx;

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n)                ir_sr <= IR_CAPT;
    else if (state == ST_CIR)   ir_sr <= IR_CAPT;
    else if (state == ST_SIR)   ir_sr <= {tdi, ir_sr[IR_W-1:1]};

  always_ff @(negedge tck or negedge trst_n)
    if (!trst_n)                ir <= OP_IDCODE;
    else if (state == ST_TLR)   ir <= OP_IDCODE;
    else if (state == ST_UIR)   ir <= ir_sr;

  assign sel_id  = (ir == OP_IDCODE);
  assign bsr_sel = (ir == OP_EXTEST) || (ir == OP_SAMPLE);

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n) begin
      id_sr <= ID_WORD;
      byp   <= 1'b0;
    end else if (state == ST_CDR) begin
      id_sr <= ID_WORD;
      byp   <= 1'b0;
    end else if (state == ST_SDR) begin
      id_sr <= {tdi, id_sr[ID_W-1:1]};
      byp   <= tdi;
    end

  assign dr_bit = sel_id ? id_sr[0] : (bsr_sel ? bsr_so : byp);

  always_ff @(negedge tck or negedge trst_n)
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo_en <= (state == ST_SIR) || (state == ST_SDR);
      tdo    <= (state == ST_SIR) ? ir_sr[0] : ((state == ST_SDR) ? dr_bit : 1'b0);
    end

  assign bsr_capture = bsr_sel && (state == ST_CDR);
  assign bsr_shift   = bsr_sel && (state == ST_SDR);
  assign bsr_update  = bsr_sel && (state == ST_UDR);
  assign pin_ctl     = (ir == OP_EXTEST) || (ir == OP_CLAMP);
  assign pin_hiz     = (ir == OP_HIGHZ);

endmodule

// File: rtl/jtag_tap_chk.sv
module jtag_tap_chk #(
  parameter int IR_W = 3
) (
  input logic            tck,
  input logic            trst_n,
  input logic [3:0]      state,
  input logic [IR_W-1:0] ir,
  input logic [IR_W-1:0] ir_sr,
  input logic            tdo_en,
  input logic            bsr_sel,
  input logic            bsr_capture,
  input logic            bsr_shift,
  input logic            bsr_update,
  input logic            pin_ctl,
  input logic            pin_hiz
);
  localparam logic [3:0] C_TLR = 4'hF, C_CIR = 4'hE, C_SIR = 4'hA, C_SDR = 4'h2;

  p_tdo_en_shift_r8: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_en == ((state == C_SIR) || (state == C_SDR)));

  p_strobe_onehot_r7: assert property (@(posedge tck) disable iff (!trst_n)
    $onehot0({bsr_capture, bsr_shift, bsr_update}));

  p_strobe_needs_sel_r7: assert property (@(posedge tck) disable iff (!trst_n)
    (bsr_capture || bsr_shift || bsr_update) |-> bsr_sel);

  p_pin_modes_r9: assert property (@(posedge tck) disable iff (!trst_n)
    !(pin_ctl && pin_hiz));

  p_tlr_idcode_r2: assert property (@(posedge tck) disable iff (!trst_n)
    (state == C_TLR && $past(state) == C_TLR) |-> ir == IR_W'(1));

  p_ir_capture_r3: assert property (@(posedge tck) disable iff (!trst_n)
    ($past(state) == C_CIR) |-> ir_sr == IR_W'(1));
endmodule

bind jtag_tap jtag_tap_chk #(.IR_W(IR_W)) u_chk (
  .tck(tck), .trst_n(trst_n), .state(state), .ir(ir), .ir_sr(ir_sr),
  .tdo_en(tdo_en), .bsr_sel(bsr_sel), .bsr_capture(bsr_capture),
  .bsr_shift(bsr_shift), .bsr_update(bsr_update),
  .pin_ctl(pin_ctl), .pin_hiz(pin_hiz)
);

// File: tb/sim_jtag_tap.sv
`timescale 1ns/1ps
module sim_jtag_tap;
  logic tck = 1'b0, tms = 1'b1, tdi = 1'b0, trst_n = 1'b0, bsr_so = 1'b0;
  logic tdo, tdo_en, bsr_sel, bsr_capture, bsr_shift, bsr_update, pin_ctl, pin_hiz;

  jtag_tap u0 (.tck(tck), .tms(tms), .tdi(tdi), .trst_n(trst_n), .bsr_so(bsr_so),
    .tdo(tdo), .tdo_en(tdo_en), .bsr_sel(bsr_sel), .bsr_capture(bsr_capture),
    .bsr_shift(bsr_shift), .bsr_update(bsr_update), .pin_ctl(pin_ctl), .pin_hiz(pin_hiz));

  always #4 tck = ~tck;

  localparam int M_TLR = 0, M_RTI = 1, M_SELDR = 2, M_CDR = 3, M_SDR = 4, M_E1DR = 5,
                 M_PDR = 6, M_E2DR = 7, M_UDR = 8, M_SELIR = 9, M_CIR = 10, M_SIR = 11,
                 M_E1IR = 12, M_PIR = 13, M_E2IR = 14, M_UIR = 15;
  localparam logic [31:0] ID_EXP = 32'h104B8067;

  int vectors = 0, errors = 0;
  int m_st;
  logic [2:0] m_ir, m_irs;
  logic [31:0] m_id;
  logic m_byp, m_tdo, m_en;

  function automatic int nxt(int s, logic t);
    case (s)
      M_TLR:   return t ? M_TLR : M_RTI;
      M_RTI:   return t ? M_SELDR : M_RTI;
      M_SELDR: return t ? M_SELIR : M_CDR;
      M_CDR, M_SDR: return t ? M_E1DR : M_SDR;
      M_E1DR:  return t ? M_UDR : M_PDR;
      M_PDR:   return t ? M_E2DR : M_PDR;
      M_E2DR:  return t ? M_UDR : M_SDR;
      M_UDR, M_UIR: return t ? M_SELDR : M_RTI;
      M_SELIR: return t ? M_TLR : M_CIR;
      M_CIR, M_SIR: return t ? M_E1IR : M_SIR;
      M_E1IR:  return t ? M_UIR : M_PIR;
      M_PIR:   return t ? M_E2IR : M_PIR;
      default: return t ? M_UIR : M_SIR;
    endcase
  endfunction

  function automatic logic m_bsel();
    return (m_ir == 3'd0) || (m_ir == 3'd2);
  endfunction

  task automatic chk(input logic got, input logic exp, input string tag);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk(tdo_en, m_en, "R8 tdo_en");
    chk(tdo, m_tdo, "R8 tdo");
    chk(bsr_sel, m_bsel(), "R7 bsr_sel");
    chk(bsr_capture, m_bsel() && m_st == M_CDR, "R7 capture");
    chk(bsr_shift, m_bsel() && m_st == M_SDR, "R7 shift");
    chk(bsr_update, m_bsel() && m_st == M_UDR, "R7 update");
    chk(pin_ctl, m_ir == 3'd0 || m_ir == 3'd4, "R9 pin_ctl");
    chk(pin_hiz, m_ir == 3'd5, "R9 pin_hiz");
  endtask

  task automatic model_reset();
    m_st = M_TLR; m_ir = 3'b001; m_irs = 3'b001; m_id = ID_EXP;
    m_byp = 1'b0; m_tdo = 1'b0; m_en = 1'b0;
  endtask

  task automatic step(input logic t, input logic d);
    int old;
    tms = t; tdi = d;
    @(posedge tck);
    old = m_st;
    m_st = nxt(old, t);
    if (old == M_CIR) m_irs = 3'b001;
    else if (old == M_SIR) m_irs = {d, m_irs[2:1]};
    if (old == M_CDR) begin m_id = ID_EXP; m_byp = 1'b0; end
    else if (old == M_SDR) begin m_id = {d, m_id[31:1]}; m_byp = d; end
    @(negedge tck);
    if (m_st == M_TLR) m_ir = 3'b001;
    else if (m_st == M_UIR) m_ir = m_irs;
    m_en = (m_st == M_SIR) || (m_st == M_SDR);
    m_tdo = (m_st == M_SIR) ? m_irs[0] :
            (m_st == M_SDR) ? ((m_ir == 3'd1) ? m_id[0] : (m_bsel() ? bsr_so : m_byp)) : 1'b0;
    #1 compare_all();
  endtask

  task automatic load_ir(input logic [2:0] op, output logic [2:0] cap);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 3; i++) begin
      cap[i] = tdo;
      step(i == 2, op[i]);
    end
    step(1, 0); step(0, 0);
  endtask

  task automatic shift_dr(input int n, input logic [31:0] din, output logic [31:0] dout);
    dout = '0;
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo;
      step(i == n - 1, din[i]);
    end
    step(1, 0); step(0, 0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [2:0] cap;
    logic [31:0] dout;
    model_reset();
    #11;
    chk(tdo_en, 1'b0, "R1 reset tdo_en");
    chk(bsr_sel, 1'b0, "R1 reset selects ID");
    chk(pin_ctl | pin_hiz, 1'b0, "R1 reset pins");
    @(negedge tck); #1 trst_n = 1'b1;
    step(0, 0);
    chk(tdo_en, 1'b0, "R8 idle tdo_en");

    shift_dr(32, 32'hA5A5_0F0F, dout);
    for (int b = 0; b < 32; b++) chk(dout[b], ID_EXP[b], "R5 id bit");

    for (int op = 0; op < 8; op++) begin
      bsr_so = op[0];
      load_ir(op[2:0], cap);
      chk(cap[0], 1'b1, "R3 capture bit0");
      chk(cap[1], 1'b0, "R3 capture bit1");
      chk(cap[2], 1'b0, "R3 capture bit2");
      chk(bsr_sel, op == 0 || op == 2, "R4 decode sel");
      chk(pin_ctl, op == 0 || op == 4, "R9 pin_ctl decode");
      chk(pin_hiz, op == 5, "R9 pin_hiz decode");
      shift_dr(8, 32'h0000_00B3, dout);
      if (op == 1) begin
        for (int b = 0; b < 8; b++) chk(dout[b], ID_EXP[b], "R4 idcode path");
      end else if (op == 0 || op == 2) begin
        for (int b = 0; b < 8; b++) chk(dout[b], op[0], "R7 boundary path");
      end else begin
        chk(dout[0], 1'b0, "R6 bypass captures 0");
        for (int b = 1; b < 8; b++) chk(dout[b], 8'hB3 >> (b - 1), "R6 bypass delay");
      end
    end

    load_ir(3'd5, cap);
    step(1, 0); step(0, 0); step(0, 0); step(0, 1);
    for (int k = 0; k < 5; k++) step(1, 0);
    chk(tdo_en, 1'b0, "R2 tms reset tdo_en");
    chk(pin_hiz, 1'b0, "R2 tms reset restores IDCODE");
    step(0, 0);
    shift_dr(32, 32'h0, dout);
    chk(dout == ID_EXP, 1'b1, "R2 id after tms reset");

    load_ir(3'd4, cap);
    step(1, 0); step(1, 0); step(0, 0); step(0, 1);
    chk(tdo_en, 1'b1, "R8 shift-ir enable");
    trst_n = 1'b0; tms = 1'b1;
    #1 model_reset();
    chk(tdo_en, 1'b0, "R1 async tdo_en");
    chk(tdo, 1'b0, "R1 async tdo");
    chk(pin_ctl, 1'b0, "R1 async ir IDCODE");
    @(negedge tck); #1 trst_n = 1'b1;
    step(0, 0);
    shift_dr(32, 32'h0, dout);
    chk(dout == ID_EXP, 1'b1, "R1 id after async reset");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule